// File: doc/BRIEF.md
# MDIO Management Register Access Engine

This block turns a single 32-bit write into one clause-22 management frame on the MDC/MDIO line pair. Software writes a command word into one register. The word carries a start flag, a direction flag, the PHY address, the PHY register address and, for writes, the data. The engine then serialises the frame. During a read it releases MDIO so the PHY can drive the turnaround and the data.

The same register reports the outcome. The start flag in bit 31 reads as 1 for as long as the frame is on the wire, and the engine clears it when the last bit has been clocked out. Software polls for that clear bit. For a read, the 16 bits returned by the PHY are in the low half of the register by the time bit 31 drops. While a frame is running, the register does not accept new commands. MDC is derived from the system clock by a parameterised divider and is held low between frames.

Top module: `mdio_access_engine`

## Requirements
- R1: After reset the register reads 0x00000000, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: Register fields are: bit 31 request flag, bit 30 direction (1 = write, 0 = read), bits 29:26 spare, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. A write with bit 31 set starts a frame. Bit 31 reads 1 from the cycle after that write until the frame ends, then reads 0.
- R3: A write frame is 64 MDC periods, sent most significant bit first: 32 ones, start code 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then 16 data bits. MDIO is driven for the whole frame.
- R4: A read frame uses opcode 10. The engine drives MDIO for the first 46 bits and releases it (mdio_oe = 0) for the 2 turnaround bits and the 16 data bits.
- R5: During a read, MDIO is sampled at each rising MDC edge of the 16 data bits, most significant bit first. The sampled value is in bits 15:0 when bit 31 clears, and bits 30:16 keep the command.
- R6: After a write frame completes, bits 30:0 still hold the command that was written.
- R7: A register write that arrives while bit 31 reads 1 is ignored. The register contents and the frame in progress are unaffected.
- R8: A write with bit 31 clear loads the register but starts no frame, and MDC stays low.
- R9: An MDC period is 2 x MDC_HALF_CYCLES system clocks, high half second. Driven MDIO values change only at falling MDC edges.
- R10: Writing 0xC0A09000 produces a write frame of data 0x9000 to register 0 of PHY address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_data | input | 32 | Command word to write |
| reg_rd_data | output | 32 | Current register contents (status and read result) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable, 1 = engine drives the line |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The assertions check the rules that hold on every cycle. MDC stays low between frames, and each MDC rise comes only after a full half-period count. The preamble is all ones with the line driven. A write frame never releases MDIO. Bit 31 stays set while a frame is active and drops right after the last bit. A write that arrives while busy leaves the command fields untouched.

Only the bench scenarios can show the bit-exact frame contents for different addresses and data. They also show that the PHY's reply lands in the low half of the register in the right bit order, that a command written mid-frame does not disturb the frame on the line, and that a write without the request flag produces no MDC activity.

// File: rtl/mdio_eng_pkg.sv
`timescale 1ns/1ps
// Shared constants, the command-register layout and the frame builder for the
// management access engine. Assumes clause-22 framing with a full preamble.
package mdio_eng_pkg;

    localparam int FRAME_BITS    = 64;
    localparam int PREAMBLE_BITS = 32;
    localparam int TA_FIRST      = 46;   // index of first turnaround bit
    localparam int DATA_FIRST    = 48;   // index of first data bit
    localparam int IDX_W         = $clog2(FRAME_BITS);

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    // Command register layout, bit 31 down to bit 0.
    typedef struct packed {
        logic        req;
        logic        is_wr;
        logic [3:0]  spare;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mgmt_cmd_t;

    // Assemble the serial frame, first bit on the wire in the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dat;
        op  = c.is_wr ? OP_WRITE : OP_READ;
        ta  = c.is_wr ? TA_DRIVE : 2'b00;
        dat = c.is_wr ? c.data   : 16'h0000;
        return {{PREAMBLE_BITS{1'b1}}, SOF_CODE, op, c.phy, c.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
`timescale 1ns/1ps
// MDC generator. While run is high, MDC toggles every HALF_CYCLES system
// clocks, starting low. The rise/fall event outputs are high in the cycle
// just before MDC changes. Assumes run drops only in a cycle where MDC falls,
// so MDC is always low while idle.
module mdc_divider #(
    parameter int HALF_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Wrap of the half-period counter while running.
    assign wrap     = run && (cnt_q == CNT_LAST);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap &&  mdc;

    // Half-period counter and MDC toggle; held idle while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_mdc_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    assert_mdc_rise_after_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($past(cnt_q) == CNT_LAST && $past(run)));

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
// Frame sequencer. Loads a command on start, shifts one frame bit per MDC
// period (new bit after each falling MDC), releases MDIO for the turnaround
// and data of a read, and samples read data on rising MDC. Assumes start is
// only asserted while inactive.
module mdio_frame_seq
    import mdio_eng_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mgmt_cmd_t   cmd,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_in,
    output logic        active,
    output logic        done,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PREAMBLE_BITS);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]      bit_idx_q;
    logic                  is_rd_q;

    assign done     = active && fall_evt && (bit_idx_q == IDX_LAST);
    assign mdio_out = active ? shreg_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe  = active && !(is_rd_q && (bit_idx_q >= IDX_TA));

    // Frame shift register and bit position, advanced on falling MDC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_idx_q <= '0;
            is_rd_q   <= 1'b0;
            active    <= 1'b0;
        end else if (start) begin
            shreg_q   <= build_frame(cmd);
            bit_idx_q <= '0;
            is_rd_q   <= !cmd.is_wr;
            active    <= 1'b1;
        end else if (active && fall_evt) begin
            if (bit_idx_q == IDX_LAST) begin
                active <= 1'b0;
            end else begin
                bit_idx_q <= bit_idx_q + 1'b1;
                shreg_q   <= {shreg_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Read data capture on rising MDC during the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            rd_data <= '0;
        end else if (active && rise_evt && is_rd_q && (bit_idx_q >= IDX_DATA)) begin
            rd_data <= {rd_data[14:0], mdio_in};
        end
    end

    assert_preamble_driven_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_idx_q < IDX_PRE) |-> (mdio_out && mdio_oe));

    assert_write_never_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !is_rd_q) |-> mdio_oe);

    assert_out_changes_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(fall_evt)) |-> $stable(mdio_out));

endmodule

// File: rtl/mdio_access_engine.sv
`timescale 1ns/1ps
// Management access engine top. Holds the single command/result register,
// accepts a write only while no frame is running, launches a frame when the
// request bit is written as 1, clears the request bit at frame end and
// deposits read data in the low half. Assumes one host write port.
module mdio_access_engine
    import mdio_eng_pkg::*;
#(
    parameter int MDC_HALF_CYCLES = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    mgmt_cmd_t   cmd_q;
    mgmt_cmd_t   wr_cmd;
    logic        accept;
    logic        launch;
    logic        seq_active;
    logic        seq_done;
    logic        rise_evt;
    logic        fall_evt;
    logic [15:0] seq_rd_data;

    assign wr_cmd      = mgmt_cmd_t'(reg_wr_data);
    assign accept      = reg_wr_en && !cmd_q.req;
    assign launch      = accept && wr_cmd.req;
    assign reg_rd_data = 32'(cmd_q);

    // Command/result register: host load when idle, completion update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (seq_done) begin
            cmd_q.req <= 1'b0;
            if (!cmd_q.is_wr) begin
                cmd_q.data <= seq_rd_data;
            end
        end else if (accept) begin
            cmd_q <= wr_cmd;
        end
    end

    mdc_divider #(
        .HALF_CYCLES (MDC_HALF_CYCLES)
    ) u_mdc_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_active),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .cmd      (wr_cmd),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_in  (mdio_in),
        .active   (seq_active),
        .done     (seq_done),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .rd_data  (seq_rd_data)
    );

    assert_req_held_while_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> reg_rd_data[31]);

    assert_req_clears_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !reg_rd_data[31]);

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[31] && reg_wr_en && !seq_done) |=> $stable(reg_rd_data[30:16]));

    assert_no_frame_without_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_data[31]) |=> !mdio_oe || reg_rd_data[31]);

endmodule

// File: tb/mdio_access_engine_tb.sv
`timescale 1ns/1ps
module mdio_access_engine_tb;
    localparam int HALF   = 25;
    localparam real TCLK  = 8.0;
    localparam real TMDC  = 2.0 * HALF * TCLK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] exp_out_q[$];
    logic [63:0] exp_oe_q[$];

    logic [15:0] phy_resp = 16'h0;
    int          rises_seen = 0;
    int          total_rises = 0;

    always #(TCLK/2) clk = ~clk;

    mdio_access_engine #(.MDC_HALF_CYCLES(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .mdio_in(mdio_in)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Expected frame from the requirement text (R3, R4).
    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        logic wr;
        wr = c[30];
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), c[25:21], c[20:16],
                (wr ? 2'b10 : 2'b00), (wr ? c[15:0] : 16'h0)};
    endfunction

    function automatic logic [63:0] exp_oe(input logic [31:0] c);
        return c[30] ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    endfunction

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (reg_rd_data[31] && n < 10000) begin
            @(negedge clk);
            n++;
        end
        check(!reg_rd_data[31], req, 64'(reg_rd_data), 64'(reg_rd_data & 32'h7FFF_FFFF));
    endtask

    // Driver: push expectation, launch, check busy and final register.
    task automatic run_txn(input logic [31:0] c, input logic [15:0] resp,
                           input string req);
        logic [31:0] want;
        phy_resp = resp;
        exp_out_q.push_back(exp_frame(c));
        exp_oe_q.push_back(exp_oe(c));
        reg_write(c);
        check(reg_rd_data[31] == 1'b1, "R2 busy flag", 64'(reg_rd_data[31]), 64'd1);
        wait_idle("R2 request clears");
        want = c[30] ? {1'b0, c[30:0]} : {1'b0, c[30:16], resp};
        check(reg_rd_data == want, req, 64'(reg_rd_data), 64'(want));
    endtask

    // Monitor: collect each 64-bit frame at rising MDC and score it.
    initial begin
        logic [63:0] got_out = '0;
        logic [63:0] got_oe  = '0;
        logic [63:0] eo, eoe;
        realtime     t_last = 0.0;
        bit          per_bad = 1'b0;
        realtime     per_seen = 0.0;
        forever begin
            @(posedge mdc);
            #1;
            got_out = {got_out[62:0], mdio_out};
            got_oe  = {got_oe[62:0], mdio_oe};
            if (rises_seen > 0 && ($realtime - t_last) != TMDC) begin
                per_bad  = 1'b1;
                per_seen = $realtime - t_last;
            end
            t_last = $realtime;
            rises_seen++;
            total_rises++;
            if (rises_seen == 64) begin
                rises_seen = 0;
                check(!per_bad, "R9 MDC period", 64'($rtoi(per_seen)), 64'($rtoi(TMDC)));
                per_bad = 1'b0;
                if (exp_out_q.size() == 0) begin
                    check(1'b0, "R7 unexpected frame", got_out, 64'h0);
                end else begin
                    eo  = exp_out_q.pop_front();
                    eoe = exp_oe_q.pop_front();
                    check(got_oe == eoe, "R4 output enable pattern", got_oe, eoe);
                    check(((got_out ^ eo) & eoe) == 64'h0, "R3 frame bits", got_out, eo);
                end
            end
        end
    end

    // PHY model: drives reply bits after falling MDC for the read data phase.
    initial begin
        forever begin
            @(negedge mdc);
            #1;
            if (rises_seen >= 48 && rises_seen <= 63)
                mdio_in = phy_resp[63 - rises_seen];
            else if (rises_seen == 47)
                mdio_in = 1'b0;
            else
                mdio_in = 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int rises_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(reg_rd_data == 32'h0, "R1 register reset", 64'(reg_rd_data), 64'h0);
        check(mdc == 1'b0, "R1 mdc low", 64'(mdc), 64'h0);
        check(mdio_oe == 1'b0, "R1 mdio released", 64'(mdio_oe), 64'h0);

        // R10 / R6: PHY 5, register 0, data 0x9000
        run_txn(32'hC0A0_9000, 16'h0, "R10 write result register");
        // R3 / R6: extreme addresses
        run_txn(32'hC3FF_5A5A, 16'h0, "R6 write keeps command");
        // R5: read of PHY 6 register 1
        run_txn(32'h80C1_0000, 16'hA5C3, "R5 read data in low half");

        // R7: write while busy is ignored, frame unaffected
        phy_resp = 16'h8001;
        exp_out_q.push_back(exp_frame(32'h823E_1234));
        exp_oe_q.push_back(exp_oe(32'h823E_1234));
        reg_write(32'h823E_1234);
        repeat (1000) @(negedge clk);
        reg_write(32'hC000_0000);
        check(reg_rd_data == 32'h823E_1234, "R7 busy write ignored",
              64'(reg_rd_data), 64'h823E_1234);
        wait_idle("R7 request clears");
        check(reg_rd_data == 32'h023E_8001, "R5 read after ignored write",
              64'(reg_rd_data), 64'h023E_8001);

        // R8: no request bit, no frame
        repeat (10) @(negedge clk);
        rises_before = total_rises;
        reg_write(32'h4123_ABCD);
        check(reg_rd_data == 32'h4123_ABCD, "R8 register loaded",
              64'(reg_rd_data), 64'h4123_ABCD);
        repeat (300) @(negedge clk);
        check(total_rises == rises_before && mdc == 1'b0, "R8 no MDC activity",
              64'(total_rises), 64'(rises_before));

        check(exp_out_q.size() == 0, "R3 all frames seen", 64'(exp_out_q.size()), 64'h0);
        finish_run();
    end
endmodule